// File: doc/BRIEF.md
# Clock and Signal Loss Alarm Monitor

This block watches two things on a line interface. On the transmit side it checks that the transmit clock keeps toggling. It samples that clock as ordinary data in a free-running reference domain. If the sampled level stays fixed for too long, it drives a loss-of-clock flag low. On the receive side it counts receive-clock cycles in which both receive rails carry a space. If that run of zeros grows too long, it drives a loss-of-signal flag low.

Each flag has its own way of clearing. The clock flag returns high as soon as the monitored clock is seen to change level again. The signal flag returns high on the receive clock edge that samples a mark on either rail. Both quiet limits are parameters with a default of 24 cycles. This default places the point of declaration inside the tolerated band of 20 to 32 idle cycles. The block does not judge clock frequency or duty cycle.

Top module: `line_alarm_monitor`

## Requirements
- R1: While reset is high, and on the first clock edge after it, both alarm outputs are high (inactive).
- R2: When the monitored transmit clock holds one level for 33 or more reference cycles, `tx_clk_lost_n` is low.
- R3: When the monitored transmit clock changed level between 4 and 19 reference cycles ago, `tx_clk_lost_n` is high.
- R4: After the first level change of a stopped transmit clock, `tx_clk_lost_n` is high again within 4 reference cycles.
- R5: A transmit clock stuck high and one stuck low are both detected.
- R6: After 33 or more consecutive receive clock edges that sample 0 on both rails, `rx_sig_lost_n` is low.
- R7: When a mark (logic 1 on either rail) was sampled within the last 19 receive clock edges, `rx_sig_lost_n` is high.
- R8: The receive clock edge that samples a mark drives `rx_sig_lost_n` high, even when the alarm was active.
- R9: A mark on the negative rail alone counts as signal activity, the same as one on the positive rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset; must also span a receive clock edge |
| tx_clk_in | input | 1 | Monitored transmit clock, sampled as data |
| rx_clk | input | 1 | Receive clock; the rails are sampled on its rising edge |
| rx_pos | input | 1 | Receive positive rail, 1 = mark |
| rx_neg | input | 1 | Receive negative rail, 1 = mark |
| tx_clk_lost_n | output | 1 | Loss-of-clock alarm, active low |
| rx_sig_lost_n | output | 1 | Loss-of-signal alarm, active low |

## Verification
The idle counter might fail to saturate, might wrap, or might miss its clear. Any of these faults shows at a port within one tolerance window. A flag then fails to fall by the 33rd quiet cycle, rises again while the input is still idle, or falls during a run shorter than 20 cycles. A bad synchroniser or edge stage shows sooner. The clock flag then does not return within 4 cycles of a level change. A bad receive decode shows on the next edge. The signal flag stays low after a negative-rail mark. Random run lengths that cross both sides of the band test each of these cases many times.

// File: rtl/lam_pkg.sv
package lam_pkg;

  typedef enum logic {
    ALARM_ON  = 1'b0,
    ALARM_OFF = 1'b1
  } alarm_level_e;

  // Bits needed to hold values 0..lim inclusive.
  function automatic int unsigned cnt_width(input int unsigned lim);
    int unsigned w;
    w = 1;
    while ((1 << w) <= lim) w++;
    return w;
  endfunction

endpackage

// File: rtl/lam_sync.sv
module lam_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/lam_edge_detect.sv
module lam_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic toggle
);

  logic prev_level;

  always_ff @(posedge clk) begin
    if (rst) prev_level <= 1'b0;
    else     prev_level <= level;
  end

  assign toggle = level ^ prev_level;

endmodule

// File: rtl/lam_quiet_timer.sv
module lam_quiet_timer
  import lam_pkg::*;
#(
  parameter int unsigned LIMIT = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic alarm_n
);

  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] quiet_cnt;
  logic          at_limit;

  assign at_limit = (quiet_cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_cnt <= '0;
      alarm_n   <= ALARM_OFF;
    end else if (active) begin
      quiet_cnt <= '0;
      alarm_n   <= ALARM_OFF;
    end else begin
      if (!at_limit) quiet_cnt <= quiet_cnt + 1'b1;
      if (at_limit)  alarm_n   <= ALARM_ON;
    end
  end

  // R1: reset forces the flag inactive
  assert_reset_high_R1: assert property (@(posedge clk) rst |=> alarm_n);

  // R8 (and R4 on the clock side): activity restores the flag next cycle
  assert_restore_on_activity_R8: assert property (
    @(posedge clk) disable iff (rst) active |=> alarm_n);

  // R6 / R2: counter saturates at the limit and never passes it
  assert_cnt_bounded_R6: assert property (
    @(posedge clk) disable iff (rst) quiet_cnt <= LIM);

  // R2: an active alarm implies the full quiet run has been counted
  assert_alarm_saturated_R2: assert property (
    @(posedge clk) disable iff (rst) !alarm_n |-> at_limit);

  // R7: the flag never falls in a cycle that followed activity
  assert_no_fall_after_activity_R7: assert property (
    @(posedge clk) disable iff (rst) $fell(alarm_n) |-> !$past(active));

endmodule

// File: rtl/line_alarm_monitor.sv
module line_alarm_monitor #(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned TX_QUIET_LIMIT = 24,
  parameter int unsigned RX_QUIET_LIMIT = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_clk_in,
  input  logic rx_clk,
  input  logic rx_pos,
  input  logic rx_neg,
  output logic tx_clk_lost_n,
  output logic rx_sig_lost_n
);

  logic tx_sampled;
  logic tx_toggle;
  logic rx_mark;

  // Transmit clock supervision, reference domain
  lam_sync #(.STAGES(SYNC_STAGES)) u_tx_sync (
    .clk (clk),
    .rst (rst),
    .d   (tx_clk_in),
    .q   (tx_sampled)
  );

  lam_edge_detect u_tx_edge (
    .clk    (clk),
    .rst    (rst),
    .level  (tx_sampled),
    .toggle (tx_toggle)
  );

  lam_quiet_timer #(.LIMIT(TX_QUIET_LIMIT)) u_tx_timer (
    .clk     (clk),
    .rst     (rst),
    .active  (tx_toggle),
    .alarm_n (tx_clk_lost_n)
  );

  // Receive signal supervision, receive clock domain (R9: either rail)
  assign rx_mark = rx_pos | rx_neg;

  lam_quiet_timer #(.LIMIT(RX_QUIET_LIMIT)) u_rx_timer (
    .clk     (rx_clk),
    .rst     (rst),
    .active  (rx_mark),
    .alarm_n (rx_sig_lost_n)
  );

  // R9: a negative-rail mark alone restores the signal flag
  assert_neg_rail_counts_R9: assert property (
    @(posedge rx_clk) disable iff (rst) (rx_neg && !rx_pos) |=> rx_sig_lost_n);

  // R4: a sampled transmit clock change restores the clock flag
  assert_tx_recovery_R4: assert property (
    @(posedge clk) disable iff (rst) tx_toggle |=> tx_clk_lost_n);

endmodule

// File: tb/line_alarm_monitor_tb.sv
`timescale 1ns/1ps
module line_alarm_monitor_tb;

  logic clk = 1'b0;
  logic rst;
  logic tx_clk_in;
  logic rx_pos;
  logic rx_neg;
  logic tx_clk_lost_n;
  logic rx_sig_lost_n;

  int checks = 0;
  int fails  = 0;
  int tx_age = 0;
  int rx_age = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  line_alarm_monitor u_dut (
    .clk           (clk),
    .rst           (rst),
    .tx_clk_in     (tx_clk_in),
    .rx_clk        (clk),
    .rx_pos        (rx_pos),
    .rx_neg        (rx_neg),
    .tx_clk_lost_n (tx_clk_lost_n),
    .rx_sig_lost_n (rx_sig_lost_n)
  );

  // 1 = must be high, 0 = must be low, -1 = inside tolerance band
  function automatic int tx_expect(input int age);
    if (age >= 33) return 0;
    if (age >= 4 && age <= 19) return 1;
    return -1;
  endfunction

  function automatic int rx_expect(input int age);
    if (age >= 33) return 0;
    if (age <= 19) return 1;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (tx_age %0d rx_age %0d)",
               req, act, exp, tx_age, rx_age);
    end
  endtask

  // One reference cycle: advance ages by the edge just passed, then check.
  task automatic tick();
    int e;
    @(negedge clk);
    tx_age++;
    if (rx_pos || rx_neg) rx_age = 0;
    else rx_age++;
    e = tx_expect(tx_age);
    if (e >= 0) begin
      if (tx_age >= 33)      chk(tx_clk_lost_n == e[0], "R2", tx_clk_lost_n, e);
      else if (tx_age == 4)  chk(tx_clk_lost_n == e[0], "R4", tx_clk_lost_n, e);
      else                   chk(tx_clk_lost_n == e[0], "R3", tx_clk_lost_n, e);
    end
    e = rx_expect(rx_age);
    if (e >= 0) begin
      if (rx_age >= 33)      chk(rx_sig_lost_n == e[0], "R6", rx_sig_lost_n, e);
      else if (rx_age == 0)  chk(rx_sig_lost_n == e[0], "R8", rx_sig_lost_n, e);
      else                   chk(rx_sig_lost_n == e[0], "R7", rx_sig_lost_n, e);
    end
  endtask

  task automatic drive_tx(input logic v);
    if (v !== tx_clk_in) begin
      tx_clk_in = v;
      tx_age = 0;
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int tx_run;
    int rx_run;
    rst = 1'b1; tx_clk_in = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    repeat (3) @(negedge clk);
    // R1: both flags inactive while in reset
    chk(tx_clk_lost_n == 1'b1, "R1", tx_clk_lost_n, 1);
    chk(rx_sig_lost_n == 1'b1, "R1", rx_sig_lost_n, 1);
    rst = 1'b0;
    tx_age = 0; rx_age = 0;
    @(negedge clk);
    chk(tx_clk_lost_n == 1'b1, "R1", tx_clk_lost_n, 1);
    chk(rx_sig_lost_n == 1'b1, "R1", rx_sig_lost_n, 1);
    tx_age = 1; rx_age = 1;

    // R5: stuck low
    repeat (40) tick();
    chk(tx_clk_lost_n == 1'b0, "R5 stuck low", tx_clk_lost_n, 0);
    // R4: first edge clears
    drive_tx(1'b1);
    repeat (4) tick();
    chk(tx_clk_lost_n == 1'b1, "R4", tx_clk_lost_n, 1);
    // R5: stuck high
    repeat (36) tick();
    chk(tx_clk_lost_n == 1'b0, "R5 stuck high", tx_clk_lost_n, 0);
    // exact 19-cycle quiet run must not alarm (R3)
    drive_tx(1'b0);
    repeat (19) tick();
    chk(tx_clk_lost_n == 1'b1, "R3 19 cycles", tx_clk_lost_n, 1);

    // R9: negative rail only, after a long zero run
    chk(rx_sig_lost_n == 1'b0, "R6", rx_sig_lost_n, 0);
    rx_neg = 1'b1;
    tick();
    chk(rx_sig_lost_n == 1'b1, "R9", rx_sig_lost_n, 1);
    rx_neg = 1'b0;
    repeat (40) tick();
    chk(rx_sig_lost_n == 1'b0, "R6", rx_sig_lost_n, 0);
    rx_pos = 1'b1;
    tick();
    chk(rx_sig_lost_n == 1'b1, "R8", rx_sig_lost_n, 1);
    rx_pos = 1'b0;

    // Constrained random runs crossing both sides of the band
    void'($urandom(32'h5EED_1234));
    tx_run = 1 + int'($urandom_range(44));
    rx_run = int'($urandom_range(45));
    for (int i = 0; i < 6000; i++) begin
      rx_pos = 1'b0; rx_neg = 1'b0;
      if (tx_run == 0) begin
        drive_tx(~tx_clk_in);
        tx_run = ($urandom_range(3) == 0) ? 1 : 1 + int'($urandom_range(44));
      end else tx_run--;
      if (rx_run == 0) begin
        case ($urandom_range(2))
          0: rx_pos = 1'b1;
          1: rx_neg = 1'b1;
          default: begin rx_pos = 1'b1; rx_neg = 1'b1; end
        endcase
        rx_run = ($urandom_range(3) == 0) ? 0 : int'($urandom_range(45));
      end else rx_run--;
      tick();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule